// File: doc/BRIEF.md
# Video-RAM Block Copy Engine

This block moves data from anywhere in a 16-bit address space into the 8 KiB video-RAM window at 0x8000–0x9FFF, in units of 16-byte blocks. Software sets a source and a destination through an 8-bit register bus and then writes a control byte. The control byte gives the number of blocks and picks one of two modes. In the first mode every block is copied in a single burst. In the second mode one block is copied each time the display enters horizontal blank. A byte-wide master port carries the traffic, with one read cycle and then one write cycle per byte. A `busy` output tells the surrounding system to hold the processor off the bus while a burst is running.

Copies are allowed only while `color_mode` is high. Software can stop an armed horizontal-blank transfer by writing the control register again with the mode bit clear. Reading the control register shows whether a transfer is still pending and how many blocks remain.

Top module: `vram_block_copier`

## Requirements
- R1: After reset the engine is idle with source, destination and count zero. The register reads are: select 0 gives 0x00, select 1 gives 0x00, select 2 gives 0x80, select 3 gives 0x00, select 4 gives 0x80. `busy`, `mem_rd` and `mem_wr` are low.
- R2: The register selects are 0 (source bits 15:8), 1 (source bits 7:4, taken from write bits 7:4), 2 (destination bits 12:8, taken from write bits 4:0), 3 (destination bits 7:4, taken from write bits 7:4) and 4 (control). Source bits 3:0 are always zero. Every write goes to 0x8000 OR destination bits 12:4, plus the byte index.
- R3: Each byte takes two cycles. In the first, `mem_rd` is high with `mem_addr` set to the source address, and `mem_rdata` is captured. In the next, `mem_wr` is high with the destination address and `mem_wdata` equal to the captured byte. Both strobes are never high together.
- R4: A control write with bit 7 = 0, made while idle and in colour mode, copies (bits 6:0 + 1) × 16 bytes in one burst. `busy` is high from the cycle after the write for exactly 33 cycles per block.
- R5: A control write with bit 7 = 1, made in colour mode, arms block-per-blank mode without raising `busy`. Each `hblank` rising edge then copies exactly 16 bytes and decrements the count. After the block that started with count 0, the engine is idle and ignores further edges.
- R6: Only a rising edge of `hblank` starts a block. Holding `hblank` high starts no second block.
- R7: After each block, source and destination each advance by 16. The source wraps at 16 bits and the destination wraps inside the window.
- R8: A control write with bit 7 = 0 while block-per-blank mode is armed cancels it. The engine goes idle and copies nothing. The count field takes write bits 6:0.
- R9: A control read returns bit 7 = 1 when idle and 0 while a transfer is pending or running, with bits 6:0 equal to the remaining blocks minus 1. After a completed transfer it reads 0xFF.
- R10: With `color_mode` low, a control write loads the count but starts and arms nothing, and `hblank` edges copy nothing.
- R11: Register writes made while `busy` is high have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| color_mode | input | 1 | Enables copying when high |
| hblank | input | 1 | High during horizontal blank |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on select) |
| mem_addr | output | 16 | Master port address |
| mem_rd | output | 1 | Master read strobe |
| mem_wr | output | 1 | Master write strobe |
| mem_rdata | input | 8 | Read data, valid during the read cycle |
| mem_wdata | output | 8 | Write data |
| busy | output | 1 | Burst in progress; hold the processor off |

## Verification
After a starting control write, `busy` is already high at the next falling edge. The bench counts falling edges until it drops and expects 33 per block. An `hblank` rise made before a rising edge puts the first read in the very next cycle, and that block's last write comes 32 cycles later. The bench samples every port on falling edges and logs each read and write address and write byte at the falling edge of its own cycle. Byte counts, addresses and register readback are compared only after `busy` has been seen low, so no check lands inside a burst.

// File: rtl/vbc_pkg.sv
package vbc_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int CNT_W  = 7;
  localparam int BLK_LG = 4;
  localparam int WIN_LG = 13;
  localparam int SRC_HW = ADDR_W - BLK_LG;
  localparam int DST_HW = WIN_LG - BLK_LG;
  localparam int TAG_W  = ADDR_W - WIN_LG;
  localparam logic [TAG_W-1:0] WIN_TAG = 3'b100;
  localparam int SEL_W  = 3;
  localparam logic [SEL_W-1:0] SEL_SRC_HI = 3'd0;
  localparam logic [SEL_W-1:0] SEL_SRC_LO = 3'd1;
  localparam logic [SEL_W-1:0] SEL_DST_HI = 3'd2;
  localparam logic [SEL_W-1:0] SEL_DST_LO = 3'd3;
  localparam logic [SEL_W-1:0] SEL_CTRL   = 3'd4;
  typedef enum logic [1:0] {PH_IDLE, PH_READ, PH_WRITE} phase_t;
endpackage

// File: rtl/vbc_rst_sync.sv
module vbc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sh_q <= '0;
    else           sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sh_q[STAGES-1];
endmodule

// File: rtl/vbc_edge.sv
module vbc_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sig,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sig;
  end

  assign rise = sig & ~prev_q;
endmodule

// File: rtl/vbc_regs.sv
module vbc_regs
  import vbc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic              blk_done,
  input  logic              idle,
  output logic [SRC_HW-1:0] src_q,
  output logic [DST_HW-1:0] dst_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic [DATA_W-1:0] rdata
);
  logic [SRC_HW-1:0] src_d;
  logic [DST_HW-1:0] dst_d;
  logic [CNT_W-1:0]  cnt_d;

  always_comb begin
    src_d = src_q;
    dst_d = dst_q;
    cnt_d = cnt_q;
    if (blk_done) begin
      src_d = src_q + SRC_HW'(1);
      dst_d = dst_q + DST_HW'(1);
      cnt_d = cnt_q - CNT_W'(1);
    end else if (wr_en) begin
      case (sel)
        SEL_SRC_HI: src_d[SRC_HW-1:SRC_HW-DATA_W] = wdata;
        SEL_SRC_LO: src_d[SRC_HW-DATA_W-1:0] = wdata[DATA_W-1:BLK_LG];
        SEL_DST_HI: dst_d[DST_HW-1:DATA_W-BLK_LG] = wdata[WIN_LG-DATA_W-1:0];
        SEL_DST_LO: dst_d[DATA_W-BLK_LG-1:0] = wdata[DATA_W-1:BLK_LG];
        SEL_CTRL:   cnt_d = wdata[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      dst_q <= '0;
      cnt_q <= '0;
    end else begin
      src_q <= src_d;
      dst_q <= dst_d;
      cnt_q <= cnt_d;
    end
  end

  always_comb begin
    case (sel)
      SEL_SRC_HI: rdata = src_q[SRC_HW-1:SRC_HW-DATA_W];
      SEL_SRC_LO: rdata = {src_q[SRC_HW-DATA_W-1:0], {BLK_LG{1'b0}}};
      SEL_DST_HI: rdata = {WIN_TAG, dst_q[DST_HW-1:DATA_W-BLK_LG]};
      SEL_DST_LO: rdata = {dst_q[DATA_W-BLK_LG-1:0], {BLK_LG{1'b0}}};
      SEL_CTRL:   rdata = {idle, cnt_q};
      default:    rdata = '1;
    endcase
  end
endmodule

// File: rtl/vbc_seq.sv
module vbc_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic ctrl_we,
  input  logic mode_bit,
  input  logic color_mode,
  input  logic hb_rise,
  input  logic mover_idle,
  input  logic blk_done,
  input  logic last_blk,
  output logic blk_req,
  output logic gp_run,
  output logic active
);
  logic gp_q, gp_d;
  logic hb_q, hb_d;

  always_comb begin
    gp_d = gp_q;
    hb_d = hb_q;
    if (blk_done && last_blk) begin
      gp_d = 1'b0;
      hb_d = 1'b0;
    end else if (ctrl_we) begin
      if (mode_bit)  hb_d = color_mode;
      else if (hb_q) hb_d = 1'b0;
      else           gp_d = color_mode;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gp_q <= 1'b0;
      hb_q <= 1'b0;
    end else begin
      gp_q <= gp_d;
      hb_q <= hb_d;
    end
  end

  assign blk_req = mover_idle & ~ctrl_we & (gp_q | (hb_q & hb_rise & color_mode));
  assign gp_run  = gp_q;
  assign active  = gp_q | hb_q;
endmodule

// File: rtl/vbc_mover.sv
module vbc_mover
  import vbc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              blk_req,
  input  logic [SRC_HW-1:0] src_q,
  input  logic [DST_HW-1:0] dst_q,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              blk_done,
  output logic              idle
);
  phase_t              ph_q, ph_d;
  logic [BLK_LG-1:0]   idx_q, idx_d;
  logic [DATA_W-1:0]   buf_q;
  logic                buf_en;

  always_comb begin
    ph_d     = ph_q;
    idx_d    = idx_q;
    buf_en   = 1'b0;
    blk_done = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        if (blk_req) begin
          ph_d  = PH_READ;
          idx_d = '0;
        end
      end
      PH_READ: begin
        buf_en = 1'b1;
        ph_d   = PH_WRITE;
      end
      PH_WRITE: begin
        if (&idx_q) begin
          ph_d     = PH_IDLE;
          blk_done = 1'b1;
        end else begin
          idx_d = idx_q + BLK_LG'(1);
          ph_d  = PH_READ;
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      idx_q <= '0;
    end else begin
      ph_q  <= ph_d;
      idx_q <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      buf_q <= '0;
    else if (buf_en) buf_q <= mem_rdata;
  end

  assign mem_rd    = (ph_q == PH_READ);
  assign mem_wr    = (ph_q == PH_WRITE);
  assign mem_addr  = mem_wr ? {WIN_TAG, dst_q, idx_q} : {src_q, idx_q};
  assign mem_wdata = buf_q;
  assign idle      = (ph_q == PH_IDLE);
endmodule

// File: rtl/vram_block_copier.sv
module vram_block_copier
  import vbc_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              color_mode,
  input  logic              hblank,
  input  logic              reg_we,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              busy
);
  logic              rst_n_s;
  logic              hb_rise;
  logic              wr_en;
  logic              ctrl_we;
  logic              blk_req;
  logic              blk_done;
  logic              mover_idle;
  logic              gp_run;
  logic              active;
  logic [SRC_HW-1:0] src_q;
  logic [DST_HW-1:0] dst_q;
  logic [CNT_W-1:0]  cnt_q;

  assign busy    = gp_run | ~mover_idle;
  assign wr_en   = reg_we & ~busy;
  assign ctrl_we = wr_en & (reg_sel == SEL_CTRL);

  vbc_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_n_s)
  );

  vbc_edge u_edge (
    .clk(clk), .rst_n(rst_n_s), .sig(hblank), .rise(hb_rise)
  );

  vbc_regs u_regs (
    .clk(clk), .rst_n(rst_n_s), .wr_en(wr_en), .sel(reg_sel), .wdata(reg_wdata),
    .blk_done(blk_done), .idle(~active), .src_q(src_q), .dst_q(dst_q),
    .cnt_q(cnt_q), .rdata(reg_rdata)
  );

  vbc_seq u_seq (
    .clk(clk), .rst_n(rst_n_s), .ctrl_we(ctrl_we), .mode_bit(reg_wdata[DATA_W-1]),
    .color_mode(color_mode), .hb_rise(hb_rise), .mover_idle(mover_idle),
    .blk_done(blk_done), .last_blk(cnt_q == '0), .blk_req(blk_req),
    .gp_run(gp_run), .active(active)
  );

  vbc_mover u_mover (
    .clk(clk), .rst_n(rst_n_s), .blk_req(blk_req), .src_q(src_q), .dst_q(dst_q),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .blk_done(blk_done), .idle(mover_idle)
  );
endmodule

// File: rtl/vbc_checker.sv
module vbc_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        color_mode,
  input logic [2:0]  reg_sel,
  input logic [7:0]  reg_rdata,
  input logic [15:0] mem_addr,
  input logic        mem_rd,
  input logic        mem_wr,
  input logic [7:0]  mem_rdata,
  input logic [7:0]  mem_wdata,
  input logic        busy
);
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr)); // R3
  AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> mem_wr); // R3
  AST_WRITE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> mem_wdata == $past(mem_rdata)); // R3
  AST_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> mem_addr[15:13] == 3'b100); // R2
  AST_SRC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !$past(mem_wr)) |-> mem_addr[3:0] == 4'h0); // R2
  AST_BUSY_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> busy); // R4
  AST_STATUS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel == 3'd4 && busy) |-> !reg_rdata[7]); // R9
  AST_NO_START_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    (!color_mode && !busy) |=> !mem_rd); // R10
endmodule

bind vram_block_copier vbc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .color_mode(color_mode), .reg_sel(reg_sel),
  .reg_rdata(reg_rdata), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .mem_rdata(mem_rdata), .mem_wdata(mem_wdata), .busy(busy)
);

// File: tb/sim_vram_block_copier.sv
`timescale 1ns/1ps
module sim_vram_block_copier;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        color_mode = 1'b1;
  logic        hblank = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_sel = 3'd0;
  logic [7:0]  reg_wdata = 8'h00;
  logic [7:0]  reg_rdata;
  logic [15:0] mem_addr;
  logic        mem_rd, mem_wr, busy;
  logic [7:0]  mem_rdata, mem_wdata;

  always #2.5 clk = ~clk;

  vram_block_copier u0 (
    .clk(clk), .rst_n(rst_n), .color_mode(color_mode), .hblank(hblank),
    .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_rdata(mem_rdata),
    .mem_wdata(mem_wdata), .busy(busy)
  );

  function automatic logic [7:0] pat(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
  endfunction

  assign mem_rdata = pat(mem_addr);

  int checks = 0;
  int errors = 0;
  int nw = 0;
  int nr = 0;
  logic [15:0] wa [0:511];
  logic [7:0]  wd [0:511];
  logic [15:0] ra [0:511];

  always @(negedge clk) begin
    if (mem_wr && nw < 512) begin wa[nw] = mem_addr; wd[nw] = mem_wdata; nw++; end
    if (mem_rd && nr < 512) begin ra[nr] = mem_addr; nr++; end
  end

  typedef struct packed { logic [15:0] src; logic [15:0] dst; logic [7:0] ctrl; } gp_vec_t;
  localparam gp_vec_t GP_VEC [0:3] = '{
    '{16'h1234, 16'h0100, 8'h00},
    '{16'hC0DF, 16'h9FF7, 8'h01},
    '{16'hFFE0, 16'h0A00, 8'h02},
    '{16'h4000, 16'h0000, 8'h07}
  };

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk);
    reg_sel = s; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] s, output logic [7:0] v);
    @(negedge clk);
    reg_sel = s;
    #1 v = reg_rdata;
  endtask

  task automatic wait_idle(output int cyc);
    cyc = 0;
    while (busy && cyc < 20000) begin cyc++; @(negedge clk); end
  endtask

  task automatic pulse_hb();
    @(negedge clk); hblank = 1'b1;
    @(negedge clk); hblank = 0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] v;
    int cyc;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1", "busy", busy, 0);
    check("R1", "strobes", {mem_rd, mem_wr}, 0);
    rd(3'd0, v); check("R1", "src hi", v, 8'h00);
    rd(3'd1, v); check("R1", "src lo", v, 8'h00);
    rd(3'd2, v); check("R1", "dst hi", v, 8'h80);
    rd(3'd3, v); check("R1", "dst lo", v, 8'h00);
    rd(3'd4, v); check("R1", "ctrl", v, 8'h80);

    // R4 general-purpose bursts from the vector table
    for (int i = 0; i < 4; i++) begin
      logic [15:0] s_al, d_al, s_end, d_end;
      int nb, bad_r, bad_w, bad_d;
      s_al = GP_VEC[i].src & 16'hFFF0;
      d_al = GP_VEC[i].dst & 16'h1FF0;
      nb = int'(GP_VEC[i].ctrl[6:0]) + 1;
      wr(3'd0, GP_VEC[i].src[15:8]);
      wr(3'd1, GP_VEC[i].src[7:0]);
      wr(3'd2, GP_VEC[i].dst[15:8]);
      wr(3'd3, GP_VEC[i].dst[7:0]);
      nw = 0; nr = 0;
      wr(3'd4, GP_VEC[i].ctrl);
      wait_idle(cyc);
      check("R4", "busy cycles", cyc, nb * 33);
      check("R4", "bytes written", nw, nb * 16);
      check("R3", "bytes read", nr, nb * 16);
      bad_r = 0; bad_w = 0; bad_d = 0;
      for (int k = 0; k < nb * 16; k++) begin
        logic [15:0] sa, da;
        sa = s_al + 16'(k);
        da = 16'h8000 | ((d_al + 16'(k)) & 16'h1FFF);
        if (ra[k] !== sa) bad_r++;
        if (wa[k] !== da) bad_w++;
        if (wd[k] !== pat(sa)) bad_d++;
      end
      check("R3", "read addr mismatches", bad_r, 0);
      check("R2", "write addr mismatches (window, R7 advance)", bad_w, 0);
      check("R3", "data mismatches", bad_d, 0);
      s_end = s_al + 16'(nb * 16);
      d_end = 16'h8000 | ((d_al + 16'(nb * 16)) & 16'h1FFF);
      rd(3'd4, v); check("R9", "ctrl after burst", v, 8'hFF);
      rd(3'd0, v); check("R7", "src hi after", v, s_end[15:8]);
      rd(3'd1, v); check("R7", "src lo after", v, s_end[7:0]);
      rd(3'd2, v); check("R7", "dst hi after", v, d_end[15:8]);
      rd(3'd3, v); check("R7", "dst lo after", v, d_end[7:0]);
    end

    // R5 R6 R9 block-per-blank mode
    wr(3'd0, 8'h20); wr(3'd1, 8'h00); wr(3'd2, 8'h04); wr(3'd3, 8'h00);
    nw = 0; nr = 0;
    wr(3'd4, 8'h82);
    check("R5", "busy after arming", busy, 0);
    rd(3'd4, v); check("R9", "ctrl armed", v, 8'h02);
    pulse_hb(); wait_idle(cyc);
    check("R5", "bytes after first blank", nw, 16);
    check("R5", "first write addr", wa[0], 16'h8400);
    check("R5", "first read addr", ra[0], 16'h2000);
    rd(3'd4, v); check("R9", "ctrl after one", v, 8'h01);
    @(negedge clk); hblank = 1'b1;
    repeat (200) @(negedge clk);
    hblank = 1'b0;
    repeat (2) @(negedge clk);
    check("R6", "bytes after held blank", nw, 32);
    check("R7", "second block dst", wa[16], 16'h8410);
    check("R7", "second block src", ra[16], 16'h2010);
    rd(3'd4, v); check("R9", "ctrl after two", v, 8'h00);
    pulse_hb(); wait_idle(cyc);
    check("R5", "bytes after last", nw, 48);
    rd(3'd4, v); check("R9", "ctrl after done", v, 8'hFF);
    pulse_hb(); repeat (50) @(negedge clk);
    check("R5", "no copy after done", nw, 48);

    // R8 cancellation
    nw = 0;
    wr(3'd4, 8'h85);
    pulse_hb(); wait_idle(cyc);
    check("R8", "bytes before cancel", nw, 16);
    wr(3'd4, 8'h03);
    check("R8", "busy after cancel", busy, 0);
    rd(3'd4, v); check("R8", "ctrl after cancel", v, 8'h83);
    pulse_hb(); repeat (50) @(negedge clk);
    check("R8", "no copy after cancel", nw, 16);

    // R10 colour mode off
    color_mode = 1'b0;
    nw = 0;
    wr(3'd4, 8'h02);
    check("R10", "busy with mono", busy, 0);
    repeat (10) @(negedge clk);
    check("R10", "no burst with mono", nw, 0);
    rd(3'd4, v); check("R10", "ctrl with mono", v, 8'h82);
    wr(3'd4, 8'h81);
    pulse_hb(); repeat (50) @(negedge clk);
    check("R10", "no blank copy with mono", nw, 0);
    rd(3'd4, v); check("R10", "ctrl not armed", v, 8'h81);
    color_mode = 1'b1;

    // R11 writes during a burst are ignored
    wr(3'd0, 8'h30); wr(3'd1, 8'h00); wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    nw = 0; nr = 0;
    wr(3'd4, 8'h01);
    wr(3'd0, 8'h77);
    wr(3'd4, 8'h05);
    wait_idle(cyc);
    check("R11", "bytes unchanged", nw, 32);
    check("R11", "second block src", ra[16], 16'h3010);
    rd(3'd0, v); check("R11", "src hi kept", v, 8'h30);
    rd(3'd1, v); check("R11", "src lo advanced", v, 8'h20);
    rd(3'd4, v); check("R11", "ctrl done", v, 8'hFF);

    summary();
    $finish;
  end
endmodule